// File: doc/BRIEF.md
# Per-Line Trigger Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a processor. Each line has a trigger-mode bit. In edge mode a line records one request each time it rises. In level mode the request bit tracks the line. A request that is pending and unmasked, and that no in-service line of equal or higher priority is blocking, drives the interrupt output. The processor then pulses an acknowledge. The block presents the index of the winning line and marks that line in service. Later the processor writes an end-of-interrupt command carrying the line index, and the in-service mark is released.

Several wired-OR devices can share a line. Such a line should run in level mode. In edge mode a second device can raise the line before the first releases it, the line never drops, and that second request is lost. A free-running square-wave timer should stay in edge mode. In level mode it would request for half of every period, but in edge mode it gives one request per rising edge. A small write port sets the mask and mode registers and carries the end-of-interrupt command.

Top module: `irq_trig_ctl`

## Requirements
- R1: After reset every line is masked, every line is in edge mode, and the request and in-service registers are clear, so `irq_o` is low even while lines are high.
- R2: An edge-mode line records exactly one request per low-to-high transition, and that request stays recorded after the line drops until it is acknowledged.
- R3: An edge-mode line that stays high across its acknowledge and end-of-interrupt raises no new request. A new request is accepted only after the line has returned low and risen again.
- R4: A level-mode line's request follows the line. When the line drops before it is acknowledged, the request disappears.
- R5: A level-mode line that is still high when its end-of-interrupt is written raises `irq_o` again one cycle after the write, with its index on `vec_o`.
- R6: Trigger mode is independent per line. A write with `wr_sel`=1 loads the mode register, and `wr_data` bit i set to 1 puts line i in level mode.
- R7: A write with `wr_sel`=0 loads the mask register, and bit i set to 1 masks line i. A masked line keeps its recorded request and drives `irq_o` in the cycle after it is unmasked.
- R8: Priority is fixed, with line 0 highest. While `irq_o` is high, `vec_o` holds the index of the lowest-numbered eligible line.
- R9: An acknowledge (`ack_i` high for one cycle while `irq_o` is high) sets the in-service bit of the line on `vec_o` and clears that line's recorded request if the line is in edge mode. An in-service line blocks itself and every lower-priority line, but higher-priority lines still get through.
- R10: A write with `wr_sel`=2 is an end-of-interrupt command. It clears the in-service bit of the line whose index is in `wr_data[2:0]`.
- R11: Each line passes through a two-stage synchroniser and a request register, so a change on a line reaches `irq_o` on the third rising clock edge after the change.
- R12: With a square wave of period 8 cycles on line 0 and the line unmasked, a 64-cycle window shows exactly 32 cycles of `irq_o` high in level mode, and exactly 8 acknowledges in edge mode when every request is serviced at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NLINES | Interrupt request lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 mode, 2 end-of-interrupt, 3 ignored |
| wr_data | input | NLINES | Write data; for end-of-interrupt, line index in low bits |
| ack_i | input | 1 | Processor acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | IDXW | Index of the highest-priority eligible line |

## Verification
The bench builds the block with its default eight lines and a 3-bit index. With eight lines the bench can sweep every ordered pair of lines. For each pair it checks the priority choice, checks that in-service blocks the other line after an acknowledge, and checks the hand-over to the other line after the end-of-interrupt. Expected values come from min and max of the two indices. Eight lines are also few enough to mask and release each line on its own. The short 8-cycle square-wave period makes the level-mode and edge-mode request counts exact within a 64-cycle window.

// File: rtl/irq_trig_ctl.sv
module irq_trig_ctl #(
  parameter int NLINES = 8,
  parameter int IDXW   = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [NLINES-1:0] wr_data,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDXW-1:0]   vec_o
);
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_EOI  = 2'd2;

  logic [NLINES-1:0] sync_a, sync_b, prev, irr, isr, imr, lvl;
  logic [NLINES-1:0] rise, ack_oh, eoi_oh;
  logic              blocked;

  assign rise = sync_b & ~prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev   <= '0;
    end else begin
      sync_a <= line_i;
      sync_b <= sync_a;
      prev   <= sync_b;
    end

  always_comb begin
    irq_o   = 1'b0;
    vec_o   = '0;
    blocked = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      blocked = blocked | isr[i];
      if (!irq_o && !blocked && irr[i] && !imr[i]) begin
        irq_o = 1'b1;
        vec_o = IDXW'(i);
      end
    end
  end

  always_comb begin
    ack_oh = '0;
    eoi_oh = '0;
    if (ack_i && irq_o)
      ack_oh[vec_o] = 1'b1;
    if (wr_en && wr_sel == SEL_EOI && int'(wr_data[IDXW-1:0]) < NLINES)
      eoi_oh[wr_data[IDXW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      imr <= '1;
      lvl <= '0;
    end else begin
      irr <= (lvl & sync_b) | (~lvl & ((irr & ~ack_oh) | rise));
      isr <= (isr & ~eoi_oh) | ack_oh;
      if (wr_en && wr_sel == SEL_MASK) imr <= wr_data;
      if (wr_en && wr_sel == SEL_MODE) lvl <= wr_data;
    end
endmodule

// File: rtl/irq_trig_ctl_chk.sv
module irq_trig_ctl_chk #(
  parameter int NLINES = 8,
  parameter int IDXW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [NLINES-1:0] wr_data,
  input logic              ack_i,
  input logic              irq_o,
  input logic [IDXW-1:0]   vec_o,
  input logic [NLINES-1:0] irr,
  input logic [NLINES-1:0] isr,
  input logic [NLINES-1:0] imr
);
  logic [NLINES-1:0] ack_oh, eoi_oh, ack_q, eoi_q;
  logic              blk_upto;

  always_comb begin
    ack_oh   = '0;
    eoi_oh   = '0;
    blk_upto = 1'b0;
    if (ack_i && irq_o) ack_oh[vec_o] = 1'b1;
    if (wr_en && wr_sel == 2'd2 && int'(wr_data[IDXW-1:0]) < NLINES)
      eoi_oh[wr_data[IDXW-1:0]] = 1'b1;
    for (int i = 0; i < NLINES; i++)
      if (i <= int'(vec_o) && isr[i]) blk_upto = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q <= '0;
      eoi_q <= '0;
    end else begin
      ack_q <= ack_oh & ~eoi_oh;
      eoi_q <= eoi_oh & ~ack_oh;
    end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (imr == '1 && isr == '0 && irr == '0));

  a_r7_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~imr) == '0) |-> !irq_o);

  a_r8_vec_points_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irr[vec_o] && !imr[vec_o]));

  a_r9_in_service_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !blk_upto);

  a_r9_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q != '0) |-> ((isr & ack_q) == ack_q));

  a_r10_eoi_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_q != '0) |-> ((isr & eoi_q) == '0));
endmodule

bind irq_trig_ctl irq_trig_ctl_chk #(.NLINES(NLINES), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .irr(irr), .isr(isr), .imr(imr)
);

// File: tb/irq_trig_ctl_tb.sv
`timescale 1ns/1ps
module irq_trig_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_base = '0;
  logic       sq = 1'b0, sq_en = 1'b0;
  logic       wr_en = 1'b0, ack_i = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] line_i;
  logic       irq_o;
  logic [2:0] vec_o;
  int n_tests = 0, n_fail = 0;

  assign line_i = line_base | {7'b0, sq & sq_en};

  irq_trig_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  always #10 clk = ~clk;

  initial begin : sqgen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (!sq_en) begin ph = 0; sq = 1'b0; end
      else begin
        ph++;
        if (ph == 4) begin ph = 0; sq = ~sq; end
      end
    end
  end

  task automatic chk(string rq, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_base = '0; sq_en = 1'b0;
    wr_en = 1'b0; ack_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic ack(output int v);
    v = int'(vec_o);
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
  endtask

  task automatic set_lines(logic [7:0] v);
    line_base = v;
    step(3);
  endtask

  initial begin : main
    int v, lo, hi, cnt;
    logic pend;
    do_reset();
    chk("R1 idle after reset", irq_o, 0);
    set_lines(8'hFF);
    chk("R1 lines high but masked", irq_o, 0);
    wr(2'd0, 8'h00);
    chk("R7 recorded request after unmask", irq_o, 1);
    chk("R8 vec with all lines", vec_o, 0);

    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr(2'd0, 8'h01 << i);
      set_lines(8'h01 << i);
      chk("R7 masked line silent", irq_o, 0);
      wr(2'd0, 8'h00);
      chk("R7 unmask raises irq", irq_o, 1);
      chk("R7 unmask vec", vec_o, i);
    end

    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        do_reset();
        wr(2'd0, 8'h00);
        set_lines((8'h01 << a) | (8'h01 << b));
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        chk("R8 pair irq", irq_o, 1);
        chk("R8 pair vec", vec_o, lo);
        if (a != b) begin
          ack(v);
          chk("R9 acked vec", v, lo);
          chk("R9 lower line blocked", irq_o, 0);
          wr(2'd2, 8'(lo));
          chk("R10 eoi hands over irq", irq_o, 1);
          chk("R10 eoi hands over vec", vec_o, hi);
        end
      end

    do_reset();
    wr(2'd0, 8'h00);
    line_base = 8'h40;
    step(2);
    chk("R11 not yet after two edges", irq_o, 0);
    step(1);
    chk("R11 visible after three edges", irq_o, 1);

    do_reset();
    wr(2'd0, 8'h00);
    set_lines(8'h08);
    chk("R2 edge request", irq_o, 1);
    ack(v);
    wr(2'd2, 8'd3);
    step(4);
    chk("R3 held line gives no new request", irq_o, 0);
    set_lines(8'h00);
    set_lines(8'h08);
    chk("R3 new rise accepted", irq_o, 1);
    chk("R3 new rise vec", vec_o, 3);

    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    set_lines(8'h30);
    chk("R4 level line wins", vec_o, 4);
    set_lines(8'h00);
    chk("R2 edge request kept after drop", irq_o, 1);
    chk("R4 level request gone", vec_o, 5);
    ack(v);
    wr(2'd2, 8'd5);
    chk("R4 nothing left", irq_o, 0);

    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    set_lines(8'h10);
    ack(v);
    chk("R5 ack level vec", v, 4);
    chk("R5 in service blocks", irq_o, 0);
    wr(2'd2, 8'd4);
    chk("R5 re-raise after eoi", irq_o, 1);
    chk("R5 re-raise vec", vec_o, 4);

    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    set_lines(8'h06);
    ack(v);
    chk("R6 level line 1 first", v, 1);
    chk("R6 line 2 blocked", irq_o, 0);
    wr(2'd2, 8'd1);
    chk("R6 level line re-requests", vec_o, 1);
    wr(2'd0, 8'h02);
    chk("R6 edge line 2 still recorded", vec_o, 2);
    ack(v);
    wr(2'd2, 8'd2);
    chk("R6 edge line quiet while held", irq_o, 0);

    do_reset();
    wr(2'd0, 8'h00);
    set_lines(8'h20);
    ack(v);
    set_lines(8'h64);
    chk("R9 higher line passes", irq_o, 1);
    chk("R9 higher line vec", vec_o, 2);
    ack(v);
    wr(2'd2, 8'd2);
    chk("R9 line 6 blocked by 5", irq_o, 0);
    wr(2'd2, 8'd5);
    chk("R10 line 6 after eoi", vec_o, 6);

    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    sq_en = 1'b1;
    step(16);
    cnt = 0;
    for (int c = 0; c < 64; c++) begin
      step(1);
      if (irq_o) cnt++;
    end
    chk("R12 level square wave high cycles", cnt, 32);

    do_reset();
    wr(2'd0, 8'h00);
    sq_en = 1'b1;
    cnt = 0;
    pend = 1'b0;
    for (int c = 0; c < 80; c++) begin
      if (pend) begin
        ack_i = 1'b0; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'd0; pend = 1'b0;
      end else begin
        wr_en = 1'b0;
        if (irq_o) begin
          ack_i = 1'b1; pend = 1'b1;
          if (c >= 16) cnt++;
        end else ack_i = 1'b0;
      end
      step(1);
    end
    wr_en = 1'b0; ack_i = 1'b0; sq_en = 1'b0;
    chk("R12 edge square wave acks", cnt, 8);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    #3000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule